// File: doc/BRIEF.md
# Accumulator ALU with per-flag update masks

This block is the arithmetic and logic unit of a small accumulator machine. It is purely combinational: on every evaluation it takes a five-bit operation code, the accumulator operand, a second operand, and the current carry flag. The second operand comes from memory or from an immediate. It returns a result byte and a qualifier that says whether the result is to be stored. It also returns new zero, carry, half-carry and overflow flags, each with its own write mask.

The surrounding datapath owns the accumulator, the flag register and memory. It writes the result only when the result qualifier is high, and it loads each flag only when that flag's mask is high. The operation set covers:
- addition and subtraction, with and without carry;
- increment and decrement by the carry;
- two reverse-negate additions;
- two compare forms that set flags but write nothing;
- bitwise logic and a move;
- complement and two's-complement negate;
- plain shifts and shifts through the carry;
- a nibble exchange.

Single-operand operations act on the accumulator input. The data width is a parameter with a default of 8. The half-carry boundary is at half the width, which is bit 3 at the default.

Top module: `acc_alu`

## Requirements
- R1: The adding group produces these results, all modulo 256:
  - code 0 gives A+M;
  - code 1 gives A−M;
  - code 2 gives A+M+CF;
  - code 3 gives A−M−CF;
  - code 4 gives A+CF;
  - code 5 gives A−CF.
  
  Each of these codes raises the result qualifier.
- R2: Codes 0 to 9 raise all four flag masks. For additions, CF is the carry out of bit 7. For subtractions, CF is set when the unsigned minuend is less than the subtrahend plus the incoming borrow.
- R3: AC is the carry out of bit 3, or for subtractions the borrow into bit 4. OV is set when the signed two's-complement result of the 8-bit operation does not fit in 8 bits.
- R4: Code 6 gives M+NEG(A), which is M−A. Code 7 gives NEG(M)+A, which is A−M. Both write the result and use subtraction flag rules.
- R5: Code 8 (compare A−M) and code 9 (compare M−A) drive the difference on the result bus but hold the result qualifier low. ZF is set when that difference is zero.
- R6: The codes AND (10), OR (11), XOR (12) and MOV (13, result M) raise only the result and ZF masks.
- R7: NOT (14, result ~A) and NEG (15, result 0−A) raise only the result and ZF masks.
- R8: SHR (16) shifts A right and SHL (17) shifts A left. Both fill the vacated bit with zero and send the bit shifted out to CF. Only the result and CF masks are raised.
- R9: RRC (18) shifts A right with the incoming CF entering bit 7. RLC (19) shifts A left with the incoming CF entering bit 0. The bit shifted out goes to CF, and only the result and CF masks are raised.
- R10: SWAP (20) exchanges bits 7:4 with bits 3:0 and raises no flag mask.
- R11: Whenever a flag mask is low, that flag output is 0, except CF, which repeats the carry input. Codes 21 to 31 raise no mask and drive a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| acc_i | input | W | Accumulator operand (A) |
| opd_i | input | W | Memory or immediate operand (M) |
| cf_i | input | 1 | Current carry flag |
| res_o | output | W | Result byte |
| res_we_o | output | 1 | Result is to be stored |
| zf_o | output | 1 | New zero flag |
| zf_we_o | output | 1 | Zero flag update mask |
| cf_o | output | 1 | New carry flag |
| cf_we_o | output | 1 | Carry flag update mask |
| ac_o | output | 1 | New half-carry flag |
| ac_we_o | output | 1 | Half-carry update mask |
| ov_o | output | 1 | New overflow flag |
| ov_we_o | output | 1 | Overflow update mask |

## Verification
The block holds no state, so any internal fault appears at the ports in the same evaluation that applies the triggering operation.

A wrong decode entry shows as a mask pattern that does not belong to the operation. Examples are a compare that raises the result qualifier, or a shift that raises the zero mask. A wrong adder setup shows as a flipped borrow polarity or a half-carry taken from the wrong bit, and it appears only for operands that cross the relevant boundary. For that reason the directed vectors target nibble carries, signed overflow and zero results, and an arithmetic sweep covers the general case.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    ALU_ADD   = 5'd0,
    ALU_SUB   = 5'd1,
    ALU_ADDC  = 5'd2,
    ALU_SUBC  = 5'd3,
    ALU_INCC  = 5'd4,
    ALU_DECC  = 5'd5,
    ALU_NADD  = 5'd6,
    ALU_NADDR = 5'd7,
    ALU_CMP   = 5'd8,
    ALU_CMPR  = 5'd9,
    ALU_AND   = 5'd10,
    ALU_OR    = 5'd11,
    ALU_XOR   = 5'd12,
    ALU_MOV   = 5'd13,
    ALU_NOT   = 5'd14,
    ALU_NEG   = 5'd15,
    ALU_SHR   = 5'd16,
    ALU_SHL   = 5'd17,
    ALU_RRC   = 5'd18,
    ALU_RLC   = 5'd19,
    ALU_SWAP  = 5'd20
  } alu_op_e;

  typedef enum logic [3:0] {
    LU_ZERO, LU_AND, LU_OR, LU_XOR, LU_MOV, LU_NOT, LU_NEG,
    LU_SHR, LU_SHL, LU_RRC, LU_RLC, LU_SWAP
  } lu_op_e;

  typedef struct packed {
    logic res;
    logic zf;
    logic cf;
    logic ac;
    logic ov;
  } wr_mask_t;

  typedef struct packed {
    logic     use_adder;  // result and CF/AC/OV come from the adder
    logic     swap_ops;   // adder x = M, y = A
    logic     sub;        // adder subtracts y
    logic     zero_y;     // adder y forced to zero
    logic     use_cin;    // carry input feeds the adder
    lu_op_e   lu;
    wr_mask_t wr;
  } alu_ctl_t;

endpackage

// File: rtl/acc_alu_dec.sv
module acc_alu_dec
  import acc_alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output alu_ctl_t        ctl_o
);

  localparam wr_mask_t WR_ALL   = '{res: 1'b1, zf: 1'b1, cf: 1'b1, ac: 1'b1, ov: 1'b1};
  localparam wr_mask_t WR_FLAGS = '{res: 1'b0, zf: 1'b1, cf: 1'b1, ac: 1'b1, ov: 1'b1};
  localparam wr_mask_t WR_ZONLY = '{res: 1'b1, zf: 1'b1, cf: 1'b0, ac: 1'b0, ov: 1'b0};
  localparam wr_mask_t WR_CONLY = '{res: 1'b1, zf: 1'b0, cf: 1'b1, ac: 1'b0, ov: 1'b0};
  localparam wr_mask_t WR_RES   = '{res: 1'b1, zf: 1'b0, cf: 1'b0, ac: 1'b0, ov: 1'b0};

  always_comb begin
    ctl_o = '0;
    ctl_o.lu = LU_ZERO;
    case (op_i)
      ALU_ADD:   begin ctl_o.use_adder = 1'b1; ctl_o.wr = WR_ALL; end
      ALU_SUB:   begin ctl_o.use_adder = 1'b1; ctl_o.sub = 1'b1; ctl_o.wr = WR_ALL; end
      ALU_ADDC:  begin ctl_o.use_adder = 1'b1; ctl_o.use_cin = 1'b1; ctl_o.wr = WR_ALL; end
      ALU_SUBC:  begin ctl_o.use_adder = 1'b1; ctl_o.sub = 1'b1; ctl_o.use_cin = 1'b1;
                       ctl_o.wr = WR_ALL; end
      ALU_INCC:  begin ctl_o.use_adder = 1'b1; ctl_o.zero_y = 1'b1; ctl_o.use_cin = 1'b1;
                       ctl_o.wr = WR_ALL; end
      ALU_DECC:  begin ctl_o.use_adder = 1'b1; ctl_o.zero_y = 1'b1; ctl_o.use_cin = 1'b1;
                       ctl_o.sub = 1'b1; ctl_o.wr = WR_ALL; end
      ALU_NADD:  begin ctl_o.use_adder = 1'b1; ctl_o.sub = 1'b1; ctl_o.swap_ops = 1'b1;
                       ctl_o.wr = WR_ALL; end
      ALU_NADDR: begin ctl_o.use_adder = 1'b1; ctl_o.sub = 1'b1; ctl_o.wr = WR_ALL; end
      ALU_CMP:   begin ctl_o.use_adder = 1'b1; ctl_o.sub = 1'b1; ctl_o.wr = WR_FLAGS; end
      ALU_CMPR:  begin ctl_o.use_adder = 1'b1; ctl_o.sub = 1'b1; ctl_o.swap_ops = 1'b1;
                       ctl_o.wr = WR_FLAGS; end
      ALU_AND:   begin ctl_o.lu = LU_AND;  ctl_o.wr = WR_ZONLY; end
      ALU_OR:    begin ctl_o.lu = LU_OR;   ctl_o.wr = WR_ZONLY; end
      ALU_XOR:   begin ctl_o.lu = LU_XOR;  ctl_o.wr = WR_ZONLY; end
      ALU_MOV:   begin ctl_o.lu = LU_MOV;  ctl_o.wr = WR_ZONLY; end
      ALU_NOT:   begin ctl_o.lu = LU_NOT;  ctl_o.wr = WR_ZONLY; end
      ALU_NEG:   begin ctl_o.lu = LU_NEG;  ctl_o.wr = WR_ZONLY; end
      ALU_SHR:   begin ctl_o.lu = LU_SHR;  ctl_o.wr = WR_CONLY; end
      ALU_SHL:   begin ctl_o.lu = LU_SHL;  ctl_o.wr = WR_CONLY; end
      ALU_RRC:   begin ctl_o.lu = LU_RRC;  ctl_o.wr = WR_CONLY; end
      ALU_RLC:   begin ctl_o.lu = LU_RLC;  ctl_o.wr = WR_CONLY; end
      ALU_SWAP:  begin ctl_o.lu = LU_SWAP; ctl_o.wr = WR_RES; end
      default:   ctl_o.wr = '0;
    endcase
  end

endmodule

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  input  logic         cin_i,   // carry in (add) or borrow in (sub)
  output logic [W-1:0] sum_o,
  output logic         cf_o,
  output logic         ac_o,
  output logic         ov_o
);

  localparam int unsigned H = W / 2;

  logic [W-1:0] y_eff;
  logic         c_eff;
  logic [H:0]   lo_sum;
  logic [W:0]   full_sum;

  always_comb begin
    y_eff    = sub_i ? ~y_i : y_i;
    c_eff    = sub_i ? ~cin_i : cin_i;
    lo_sum   = {1'b0, x_i[H-1:0]} + {1'b0, y_eff[H-1:0]} + {{H{1'b0}}, c_eff};
    full_sum = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, c_eff};
    sum_o    = full_sum[W-1:0];
    // subtraction reports borrow, i.e. the inverted carry
    cf_o     = sub_i ? ~full_sum[W] : full_sum[W];
    ac_o     = sub_i ? ~lo_sum[H]   : lo_sum[H];
    ov_o     = (x_i[W-1] == y_eff[W-1]) && (full_sum[W-1] != x_i[W-1]);
  end

endmodule

// File: rtl/acc_alu_lu.sv
module acc_alu_lu
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  lu_op_e       lu_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);

  localparam int unsigned H = W / 2;

  always_comb begin
    res_o  = '0;
    cout_o = 1'b0;
    case (lu_i)
      LU_AND:  res_o = a_i & m_i;
      LU_OR:   res_o = a_i | m_i;
      LU_XOR:  res_o = a_i ^ m_i;
      LU_MOV:  res_o = m_i;
      LU_NOT:  res_o = ~a_i;
      LU_NEG:  res_o = ~a_i + {{(W-1){1'b0}}, 1'b1};
      LU_SHR:  begin res_o = {1'b0, a_i[W-1:1]};  cout_o = a_i[0];   end
      LU_SHL:  begin res_o = {a_i[W-2:0], 1'b0};  cout_o = a_i[W-1]; end
      LU_RRC:  begin res_o = {cin_i, a_i[W-1:1]}; cout_o = a_i[0];   end
      LU_RLC:  begin res_o = {a_i[W-2:0], cin_i}; cout_o = a_i[W-1]; end
      LU_SWAP: res_o = {a_i[H-1:0], a_i[W-1:H]};
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    acc_i,
  input  logic [W-1:0]    opd_i,
  input  logic            cf_i,
  output logic [W-1:0]    res_o,
  output logic            res_we_o,
  output logic            zf_o,
  output logic            zf_we_o,
  output logic            cf_o,
  output logic            cf_we_o,
  output logic            ac_o,
  output logic            ac_we_o,
  output logic            ov_o,
  output logic            ov_we_o
);

  alu_ctl_t     ctl;
  logic [W-1:0] add_x, add_y, add_sum, lu_res, res;
  logic         add_cin, add_cf, add_ac, add_ov, lu_cout, cf_new;

  acc_alu_dec i_dec (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  always_comb begin
    add_x   = ctl.swap_ops ? opd_i : acc_i;
    add_y   = ctl.zero_y ? '0 : (ctl.swap_ops ? acc_i : opd_i);
    add_cin = ctl.use_cin & cf_i;
  end

  acc_alu_addsub #(.W(W)) i_addsub (
    .x_i   (add_x),
    .y_i   (add_y),
    .sub_i (ctl.sub),
    .cin_i (add_cin),
    .sum_o (add_sum),
    .cf_o  (add_cf),
    .ac_o  (add_ac),
    .ov_o  (add_ov)
  );

  acc_alu_lu #(.W(W)) i_lu (
    .lu_i   (ctl.lu),
    .a_i    (acc_i),
    .m_i    (opd_i),
    .cin_i  (cf_i),
    .res_o  (lu_res),
    .cout_o (lu_cout)
  );

  always_comb begin
    res      = ctl.use_adder ? add_sum : lu_res;
    cf_new   = ctl.use_adder ? add_cf : lu_cout;
    res_o    = res;
    res_we_o = ctl.wr.res;
    zf_we_o  = ctl.wr.zf;
    cf_we_o  = ctl.wr.cf;
    ac_we_o  = ctl.wr.ac;
    ov_we_o  = ctl.wr.ov;
    zf_o     = ctl.wr.zf & ~|res;
    cf_o     = ctl.wr.cf ? cf_new : cf_i;
    ac_o     = ctl.wr.ac & add_ac;
    ov_o     = ctl.wr.ov & add_ov;
  end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    acc_i,
  input logic [W-1:0]    opd_i,
  input logic            cf_i,
  input logic [W-1:0]    res_o,
  input logic            res_we_o,
  input logic            zf_o,
  input logic            zf_we_o,
  input logic            cf_o,
  input logic            cf_we_o,
  input logic            ac_o,
  input logic            ac_we_o,
  input logic            ov_o,
  input logic            ov_we_o
);

  localparam int unsigned H = W / 2;

  always_comb begin
    if (op_i == ALU_ADD) begin
      p_add_result_r1: assert (res_o == acc_i + opd_i)
        else $error("R1 add result mismatch");
    end
    if (op_i <= ALU_CMPR) begin
      p_arith_masks_r2: assert (zf_we_o && cf_we_o && ac_we_o && ov_we_o)
        else $error("R2 arithmetic mask low");
    end
    if (op_i == ALU_SUB) begin
      p_sub_borrow_r2: assert (cf_o == (acc_i < opd_i))
        else $error("R2 borrow wrong");
      p_sub_halfborrow_r3: assert (ac_o == (acc_i[H-1:0] < opd_i[H-1:0]))
        else $error("R3 half borrow wrong");
    end
    if (op_i == ALU_NADD) begin
      p_nadd_result_r4: assert (res_o == opd_i - acc_i && res_we_o)
        else $error("R4 reverse negate-add wrong");
    end
    if (op_i == ALU_CMP || op_i == ALU_CMPR) begin
      p_cmp_nowrite_r5: assert (!res_we_o) else $error("R5 compare writes");
      p_cmp_zero_r5: assert (zf_o == (acc_i == opd_i)) else $error("R5 compare ZF");
    end
    if (op_i >= ALU_AND && op_i <= ALU_NEG) begin
      p_logic_zonly_r6: assert (res_we_o && zf_we_o && !cf_we_o && !ac_we_o && !ov_we_o)
        else $error("R6/R7 logic masks");
    end
    if (op_i == ALU_SHR || op_i == ALU_SHL) begin
      p_shift_conly_r8: assert (res_we_o && cf_we_o && !zf_we_o && !ac_we_o && !ov_we_o)
        else $error("R8 shift masks");
    end
    if (op_i == ALU_RRC) begin
      p_rrc_inbit_r9: assert (res_o[W-1] == cf_i && cf_o == acc_i[0])
        else $error("R9 rotate right");
    end
    if (op_i == ALU_SWAP) begin
      p_swap_noflags_r10: assert (!zf_we_o && !cf_we_o && !ac_we_o && !ov_we_o)
        else $error("R10 swap touches flags");
    end
    if (!cf_we_o) begin
      p_cf_hold_r11: assert (cf_o == cf_i) else $error("R11 masked CF");
    end
    if (op_i > ALU_SWAP) begin
      p_reserved_idle_r11: assert (!res_we_o && !zf_we_o && !cf_we_o && !ac_we_o && !ov_we_o)
        else $error("R11 reserved writes");
    end
  end

endmodule

bind acc_alu acc_alu_chk #(.W(W)) i_chk (
  .op_i     (op_i),
  .acc_i    (acc_i),
  .opd_i    (opd_i),
  .cf_i     (cf_i),
  .res_o    (res_o),
  .res_we_o (res_we_o),
  .zf_o     (zf_o),
  .zf_we_o  (zf_we_o),
  .cf_o     (cf_o),
  .cf_we_o  (cf_we_o),
  .ac_o     (ac_o),
  .ac_we_o  (ac_we_o),
  .ov_o     (ov_o),
  .ov_we_o  (ov_we_o)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;
  import acc_alu_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 30;

  // op, a, m, cin, expected result, masks {res,zf,cf,ac,ov}, flags {zf,cf,ac,ov}, requirement
  typedef struct packed {
    logic [4:0] op;
    logic [7:0] a;
    logic [7:0] m;
    logic       cin;
    logic [7:0] res;
    logic [4:0] we;
    logic [3:0] fl;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{5'd0,  8'h0F, 8'h01, 1'b0, 8'h10, 5'b11111, 4'b0010, 4'd3},  // R3 half carry
    '{5'd0,  8'h80, 8'h80, 1'b0, 8'h00, 5'b11111, 4'b1101, 4'd2},  // R2 carry, zero, ov
    '{5'd0,  8'h7F, 8'h01, 1'b0, 8'h80, 5'b11111, 4'b0011, 4'd3},  // R3 signed ov
    '{5'd1,  8'h10, 8'h01, 1'b0, 8'h0F, 5'b11111, 4'b0010, 4'd3},  // R3 half borrow
    '{5'd1,  8'h00, 8'h01, 1'b0, 8'hFF, 5'b11111, 4'b0110, 4'd2},  // R2 borrow
    '{5'd1,  8'h80, 8'h01, 1'b0, 8'h7F, 5'b11111, 4'b0011, 4'd3},  // R3 sub ov
    '{5'd2,  8'h01, 8'h01, 1'b1, 8'h03, 5'b11111, 4'b0000, 4'd1},  // R1 addc
    '{5'd3,  8'h05, 8'h05, 1'b1, 8'hFF, 5'b11111, 4'b0110, 4'd1},  // R1 subc
    '{5'd4,  8'hFF, 8'h55, 1'b1, 8'h00, 5'b11111, 4'b1110, 4'd1},  // R1 incc
    '{5'd5,  8'h00, 8'h55, 1'b1, 8'hFF, 5'b11111, 4'b0110, 4'd1},  // R1 decc
    '{5'd5,  8'h80, 8'h55, 1'b0, 8'h80, 5'b11111, 4'b0000, 4'd1},  // R1 decc no carry
    '{5'd6,  8'h03, 8'h05, 1'b0, 8'h02, 5'b11111, 4'b0000, 4'd4},  // R4 M-A
    '{5'd7,  8'h03, 8'h05, 1'b0, 8'hFE, 5'b11111, 4'b0110, 4'd4},  // R4 A-M
    '{5'd8,  8'h42, 8'h42, 1'b0, 8'h00, 5'b01111, 4'b1000, 4'd5},  // R5 cmp equal
    '{5'd9,  8'h01, 8'h00, 1'b0, 8'hFF, 5'b01111, 4'b0110, 4'd5},  // R5 cmp mirrored
    '{5'd10, 8'hF0, 8'h0F, 1'b1, 8'h00, 5'b11000, 4'b1100, 4'd6},  // R6 and
    '{5'd11, 8'hF0, 8'h0F, 1'b0, 8'hFF, 5'b11000, 4'b0000, 4'd6},  // R6 or
    '{5'd12, 8'hAA, 8'hAA, 1'b0, 8'h00, 5'b11000, 4'b1000, 4'd6},  // R6 xor
    '{5'd13, 8'h12, 8'h00, 1'b1, 8'h00, 5'b11000, 4'b1100, 4'd6},  // R6 mov
    '{5'd14, 8'hFF, 8'h00, 1'b0, 8'h00, 5'b11000, 4'b1000, 4'd7},  // R7 not
    '{5'd15, 8'h01, 8'h00, 1'b0, 8'hFF, 5'b11000, 4'b0000, 4'd7},  // R7 neg
    '{5'd15, 8'h00, 8'h00, 1'b1, 8'h00, 5'b11000, 4'b1100, 4'd7},  // R7 neg zero
    '{5'd16, 8'h81, 8'h00, 1'b0, 8'h40, 5'b10100, 4'b0100, 4'd8},  // R8 shr
    '{5'd17, 8'h81, 8'h00, 1'b0, 8'h02, 5'b10100, 4'b0100, 4'd8},  // R8 shl
    '{5'd16, 8'h02, 8'h00, 1'b1, 8'h01, 5'b10100, 4'b0000, 4'd8},  // R8 zero fill
    '{5'd18, 8'h02, 8'h00, 1'b1, 8'h81, 5'b10100, 4'b0000, 4'd9},  // R9 rrc
    '{5'd19, 8'h80, 8'h00, 1'b1, 8'h01, 5'b10100, 4'b0100, 4'd9},  // R9 rlc
    '{5'd19, 8'h00, 8'h00, 1'b1, 8'h01, 5'b10100, 4'b0000, 4'd9},  // R9 rlc carry in
    '{5'd20, 8'h3C, 8'h00, 1'b1, 8'hC3, 5'b10000, 4'b0100, 4'd10}, // R10 swap
    '{5'd31, 8'hFF, 8'hFF, 1'b1, 8'h00, 5'b00000, 4'b0100, 4'd11}  // R11 reserved
  };

  logic       clk;
  logic [4:0] op;
  logic [7:0] acc, opd;
  logic       cin;
  logic [7:0] res;
  logic       res_we, zf, zf_we, cf, cf_we, ac, ac_we, ov, ov_we;
  int         checks, failures;
  logic       done;

  acc_alu i_acc_alu (
    .op_i(op), .acc_i(acc), .opd_i(opd), .cf_i(cin),
    .res_o(res), .res_we_o(res_we),
    .zf_o(zf), .zf_we_o(zf_we), .cf_o(cf), .cf_we_o(cf_we),
    .ac_o(ac), .ac_we_o(ac_we), .ov_o(ov), .ov_we_o(ov_we)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic apply(input logic [4:0] o, input logic [7:0] a, input logic [7:0] m,
                       input logic c);
    @(posedge clk);
    op = o; acc = a; opd = m; cin = c;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] e_res, input logic [4:0] e_we,
                       input logic [3:0] e_fl);
    logic [4:0] got_we;
    logic [3:0] got_fl;
    got_we = {res_we, zf_we, cf_we, ac_we, ov_we};
    got_fl = {zf, cf, ac, ov};
    checks++;
    if (res !== e_res || got_we !== e_we || got_fl !== e_fl) begin
      failures++;
      $display("FAIL %s op=%0d a=%h m=%h c=%b: res=%h we=%b fl=%b expected res=%h we=%b fl=%b",
               req, op, acc, opd, cin, res, got_we, got_fl, e_res, e_we, e_fl);
    end
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    op = 5'd0; acc = '0; opd = '0; cin = 1'b0;

    // R11: idle at a reserved code before anything else
    apply(5'd25, 8'h00, 8'h00, 1'b0);
    check("R11", 8'h00, 5'b00000, 4'b0000);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i].op, VEC[i].a, VEC[i].m, VEC[i].cin);
      check($sformatf("R%0d", VEC[i].req), VEC[i].res, VEC[i].we, VEC[i].fl);
    end

    // R2 and R3 sweep: add and subtract flags from integer arithmetic
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        int a, m, s, sa, sm, sv;
        logic e_cf, e_ac, e_ov, e_zf;
        a  = (i * 37 + 5) % 256;
        m  = (j * 53 + 11) % 256;
        sa = (a > 127) ? a - 256 : a;
        sm = (m > 127) ? m - 256 : m;
        s  = a + m; sv = sa + sm;
        e_cf = (s > 255); e_ac = ((a % 16) + (m % 16)) > 15;
        e_ov = (sv > 127) || (sv < -128); e_zf = (s % 256) == 0;
        apply(5'd0, 8'(a), 8'(m), 1'b0);
        check("R2/R3 add sweep", 8'(s % 256), 5'b11111, {e_zf, e_cf, e_ac, e_ov});
        s  = (a - m + 256) % 256; sv = sa - sm;
        e_cf = (a < m); e_ac = (a % 16) < (m % 16);
        e_ov = (sv > 127) || (sv < -128); e_zf = (s == 0);
        apply(5'd1, 8'(a), 8'(m), 1'b0);
        check("R2/R3 sub sweep", 8'(s), 5'b11111, {e_zf, e_cf, e_ac, e_ov});
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule